// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Router

This block gathers up to 64 level-sensitive device interrupt lines into one shared raw request vector and presents it to four processors, each through its own 64-bit enable mask. A processor's hard-interrupt line is raised whenever at least one source that its mask enables is currently requesting. One source position (bit 55) is not taken from the device lines: the output of a cascaded legacy interrupt controller drives it instead.

Software reaches the block over a simple 64-bit register bus with a 12-bit byte offset. Each processor has a writable mask register and a read-only masked-request view, and the raw vector can be read at one shared offset. Only full 64-bit accesses are honoured. Read data is registered and appears one clock after the read strobe.

Top module: `cpu_irq_router`

## Requirements
- R1: After reset every mask and the raw vector are zero, so all four `cpuIrq` bits are low and every mask reads back as zero.
- R2: Raw bit n (n other than 55) takes the level of `devIrq[n]` at each rising clock edge: set while the line is high, cleared while it is low.
- R3: Raw bit 55 takes the level of `legacyIrq`; `devIrq[55]` has no effect on the raw vector or on any output.
- R4: The mask of CPU 0, 1, 2, 3 lives at offset 0x200, 0x240, 0x600, 0x640; a full-width write stores all 64 bits, which read back unchanged.
- R5: A write to CPU i's mask offset changes only CPU i's mask; the other three keep their values.
- R6: The masked-request view of CPU 0, 1, 2, 3 at offset 0x280, 0x2C0, 0x680, 0x6C0 reads as that CPU's mask AND the raw vector.
- R7: The raw vector reads at offset 0x300.
- R8: `cpuIrq[i]` is high exactly when CPU i's mask AND the raw vector is nonzero, re-evaluated right after any clock edge that changes either the mask or the raw vector.
- R9: Writes to the masked-request offsets and to the raw offset change no state.
- R10: An access whose byte enables `regByteEn` are not all ones is invalid: a write changes nothing and a read returns all ones.
- R11: A read of any offset not listed in R4, R6 or R7 returns all ones; a write there changes nothing.
- R12: `regRdData` loads at the rising edge where `regRdEn` is high and holds its value while `regRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrq | input | 64 | Device interrupt levels, one per source |
| legacyIrq | input | 1 | Level from the cascaded legacy interrupt controller |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regByteEn | input | 8 | Byte enables; all ones marks a valid 64-bit access |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Registered read data |
| cpuIrq | output | 4 | Hard-interrupt line per CPU |

## Verification
On every cycle the assertions check that the raw vector tracks the previous cycle's merged input levels with bit 55 from the legacy line, that at most one mask is written per access and the unwritten masks stay stable, that clearing a mask silences that CPU's line, and that writes to read-only offsets produce no mask strobe. The address map itself, the readback of masked views against an independent model, the all-ones response to invalid or unmapped reads and the hold of read data between reads can only be shown by the bench's directed scenarios.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int NUM_CPU    = 4;
  localparam int NUM_SRC    = 64;
  localparam int DATA_W     = 64;
  localparam int ADDR_W     = 12;
  localparam int BE_W       = DATA_W / 8;
  localparam int LEGACY_BIT = 55;
  localparam int CPU_W      = $clog2(NUM_CPU);

  localparam logic [ADDR_W-1:0] RAW_OFFSET    = 12'h300;
  localparam int                VIEW_DISTANCE = 'h80;

  typedef enum logic [1:0] {RD_MASK, RD_MASKED, RD_RAW, RD_BAD} rdsel_e;

  typedef struct packed {
    logic [NUM_CPU-1:0] maskWr;
    logic               rdLoad;
    rdsel_e             rdSel;
    logic [CPU_W-1:0]   rdCpu;
  } strobe_t;

  // CPUs 0/1 sit in the low bank, 2/3 in the high bank, 0x40 apart
  function automatic logic [ADDR_W-1:0] maskOffset(input int cpu);
    return ADDR_W'('h200 + (cpu / 2) * 'h400 + (cpu % 2) * 'h40);
  endfunction

  function automatic logic [ADDR_W-1:0] viewOffset(input int cpu);
    return ADDR_W'(int'(maskOffset(cpu)) + VIEW_DISTANCE);
  endfunction
endpackage

// File: rtl/irqr_ctrl.sv
module irqr_ctrl
  import irqr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BE_W-1:0]   regByteEn,
  output strobe_t           stb
);
  logic fullWidth;
  assign fullWidth = &regByteEn;

  always_comb begin
    stb        = '0;
    stb.rdSel  = RD_BAD;
    stb.rdLoad = regRdEn;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (fullWidth && regAddr == maskOffset(i)) begin
        stb.maskWr[i] = regWrEn;
        stb.rdSel     = RD_MASK;
        stb.rdCpu     = CPU_W'(i);
      end
      if (fullWidth && regAddr == viewOffset(i)) begin
        stb.rdSel = RD_MASKED;
        stb.rdCpu = CPU_W'(i);
      end
    end
    if (fullWidth && regAddr == RAW_OFFSET) stb.rdSel = RD_RAW;
  end

  // R5
  one_mask_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.maskWr));

  // R9
  ro_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == RAW_OFFSET || regAddr == viewOffset(0) ||
                 regAddr == viewOffset(3))) |-> stb.maskWr == '0);

  // R10
  partial_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !(&regByteEn)) |-> stb.maskWr == '0);
endmodule

// File: rtl/irqr_datapath.sv
module irqr_datapath
  import irqr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_SRC-1:0] devIrq,
  input  logic               legacyIrq,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  logic [NUM_SRC-1:0] rawIn;
  logic [NUM_SRC-1:0] rawQ;
  logic [DATA_W-1:0]  maskQ [NUM_CPU];

  always_comb begin
    rawIn             = devIrq;
    rawIn[LEGACY_BIT] = legacyIrq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= rawIn;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : gCpu
    always_ff @(posedge clk) begin
      if (!rstN)              maskQ[g] <= '0;
      else if (stb.maskWr[g]) maskQ[g] <= regWrData;
    end
    assign cpuIrq[g] = |(maskQ[g] & DATA_W'(rawQ));

    // R5
    other_mask_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
      !stb.maskWr[g] |=> $stable(maskQ[g]));

    // R8
    zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.maskWr[g] && regWrData == '0) |=> !cpuIrq[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (stb.rdLoad) begin
      case (stb.rdSel)
        RD_MASK:   regRdData <= maskQ[stb.rdCpu];
        RD_MASKED: regRdData <= maskQ[stb.rdCpu] & DATA_W'(rawQ);
        RD_RAW:    regRdData <= DATA_W'(rawQ);
        default:   regRdData <= '1;
      endcase
    end
  end

  // R2
  raw_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rawQ == $past(rawIn));

  // R3
  legacy_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rawQ[LEGACY_BIT] == $past(legacyIrq));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(regRdData));
endmodule

// File: rtl/cpu_irq_router.sv
module cpu_irq_router
  import irqr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] devIrq,
  input  logic               legacyIrq,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BE_W-1:0]    regByteEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  strobe_t stb;

  irqr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteEn(regByteEn), .stb(stb)
  );

  irqr_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .devIrq(devIrq),
    .legacyIrq(legacyIrq), .regWrData(regWrData),
    .regRdData(regRdData), .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/sim_cpu_irq_router.sv
`timescale 1ns/1ps
module sim_cpu_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] devIrq = '0;
  logic        legacyIrq = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [7:0]  regByteEn = 8'hFF;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic [3:0]  cpuIrq;

  int checks = 0, errors = 0;
  logic [63:0] expMask [4];
  logic [63:0] expRaw;
  logic [11:0] mOff [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  logic [11:0] vOff [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};

  always #2 clk = ~clk;

  cpu_irq_router u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expIrq();
    for (int i = 0; i < 4; i++) expIrq[i] = |(expMask[i] & expRaw);
  endfunction

  task automatic regWrite(input logic [11:0] a, input logic [63:0] d, input logic [7:0] be = 8'hFF);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 0; regByteEn = 8'hFF;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [63:0] d, input logic [7:0] be = 8'hFF);
    @(negedge clk);
    regRdEn = 1; regAddr = a; regByteEn = be;
    @(posedge clk); #1;
    d = regRdData;
    @(negedge clk);
    regRdEn = 0; regByteEn = 8'hFF;
  endtask

  task automatic setLevels(input logic [63:0] dev, input logic leg);
    @(negedge clk);
    devIrq = dev; legacyIrq = leg;
    expRaw = dev; expRaw[55] = leg;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    logic [63:0] d;
    check(cpuIrq == 4'b0, "R1 irq after reset", 64'(cpuIrq), 0);
    for (int i = 0; i < 4; i++) begin
      regRead(mOff[i], d);
      check(d == 0, "R1 mask after reset", d, 0);
    end
  endtask

  task automatic testRawFollow();
    logic [63:0] d;
    setLevels(64'h8000_0000_0000_0001, 0);
    regRead(12'h300, d);
    check(d == expRaw, "R2 R7 raw set", d, expRaw);
    setLevels(64'h0000_0000_0000_0001, 0);
    regRead(12'h300, d);
    check(d == expRaw, "R2 raw clear", d, expRaw);
    setLevels(64'h0, 0);
  endtask

  task automatic testLegacy();
    logic [63:0] d;
    setLevels(64'h0080_0000_0000_0000, 0);
    regRead(12'h300, d);
    check(d == 64'h0, "R3 dev55 ignored", d, 0);
    setLevels(64'h0, 1);
    regRead(12'h300, d);
    check(d == 64'h0080_0000_0000_0000, "R3 legacy drives 55", d, 64'h0080_0000_0000_0000);
    setLevels(64'h0, 0);
  endtask

  task automatic testMaskRw();
    logic [63:0] d;
    for (int i = 0; i < 4; i++) begin
      expMask[i] = 64'h1111_0000_0000_0000 * 64'(i + 1) | 64'(1 << i);
      regWrite(mOff[i], expMask[i]);
    end
    for (int i = 0; i < 4; i++) begin
      regRead(mOff[i], d);
      check(d == expMask[i], "R4 R5 mask readback", d, expMask[i]);
    end
    regWrite(mOff[2], 64'hDEAD_BEEF_0000_0004);
    expMask[2] = 64'hDEAD_BEEF_0000_0004;
    for (int i = 0; i < 4; i++) begin
      regRead(mOff[i], d);
      check(d == expMask[i], "R5 single mask updated", d, expMask[i]);
    end
  endtask

  task automatic testRouting();
    logic [63:0] d;
    setLevels(64'h0000_0000_0000_0005, 0);
    check(cpuIrq == expIrq(), "R8 irq sources 0,2", 64'(cpuIrq), 64'(expIrq()));
    for (int i = 0; i < 4; i++) begin
      regRead(vOff[i], d);
      check(d == (expMask[i] & expRaw), "R6 masked view", d, expMask[i] & expRaw);
    end
    setLevels(64'h0, 1);
    check(cpuIrq == expIrq(), "R8 irq legacy only", 64'(cpuIrq), 64'(expIrq()));
    regWrite(mOff[1], 64'h0080_0000_0000_0000);
    expMask[1] = 64'h0080_0000_0000_0000;
    #1;
    check(cpuIrq == expIrq(), "R8 irq after mask write", 64'(cpuIrq), 64'(expIrq()));
    regWrite(mOff[1], 64'h0);
    expMask[1] = 0;
    #1;
    check(cpuIrq[1] == 1'b0, "R8 irq mask cleared", 64'(cpuIrq), 64'(expIrq()));
    setLevels(64'h0, 0);
  endtask

  task automatic testReadOnly();
    logic [63:0] d;
    regWrite(vOff[0], 64'hFFFF_FFFF_FFFF_FFFF);
    regWrite(vOff[3], 64'hFFFF_FFFF_FFFF_FFFF);
    regWrite(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      regRead(mOff[i], d);
      check(d == expMask[i], "R9 masks untouched", d, expMask[i]);
    end
    regRead(12'h300, d);
    check(d == expRaw, "R9 raw untouched", d, expRaw);
    check(cpuIrq == expIrq(), "R9 irq untouched", 64'(cpuIrq), 64'(expIrq()));
  endtask

  task automatic testInvalid();
    logic [63:0] d;
    regWrite(mOff[0], 64'h0, 8'h0F);
    regRead(mOff[0], d);
    check(d == expMask[0], "R10 partial write ignored", d, expMask[0]);
    regRead(mOff[0], d, 8'hF0);
    check(d == '1, "R10 partial read all ones", d, '1);
    regRead(12'h208, d);
    check(d == '1, "R11 unmapped read", d, '1);
    regWrite(12'h204, 64'h0);
    regRead(mOff[0], d);
    check(d == expMask[0], "R11 unmapped write ignored", d, expMask[0]);
  endtask

  task automatic testReadHold();
    logic [63:0] d;
    regRead(mOff[3], d);
    repeat (3) @(posedge clk);
    regWrite(mOff[3], 64'h5);
    expMask[3] = 64'h5;
    #1;
    check(regRdData == d, "R12 read data holds", regRdData, d);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) expMask[i] = 0;
    expRaw = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(posedge clk); #1;
    testReset();
    testRawFollow();
    testLegacy();
    testMaskRw();
    testRouting();
    testReadOnly();
    testInvalid();
    testReadHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'(checks), 64'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule